// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two synchronized data lines of a low-speed USB port into a stream of received bytes. It runs on a system clock that gives exactly 11 cycles per bit. It waits for the first J-to-K transition of a packet and locks onto the double K that closes the sync field. The sample phase is re-anchored on every D- transition, so small clock mismatches are absorbed. Each centre sample is NRZI-decoded, stuffed bits are dropped, and the remaining bits are packed least significant bit first.

Each completed byte appears on `data_o` with a one-cycle `we_o` strobe, and `count_o` tracks how many bytes the current packet has delivered. An SE0 at a sample point ends the packet with a `done_o` pulse. If the packet ended part-way through a byte, `err_frame_o` pulses in the same cycle. A packet that delivers more bytes than the buffer holds is aborted with `err_ovf_o`. A sync field that stalls without a new K edge is aborted with `err_sync_o`.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, and while the line idles at J (D- high, D+ low), every output is zero and no strobe or flag pulses.
- R2: A packet starts only after a J-to-K transition (K: D- low, D+ high) whose K level still holds at the centre of the following bit. If the line returns to J before that point, reception waits for the next J-to-K transition.
- R3: After a failed double-K check, if no J-to-K transition arrives within SYNC_TMO_BITS*BIT_CLKS clocks, `err_sync_o` pulses for one cycle and the block returns to idle.
- R4: A centre sample equal in D- level to the previous one decodes as 1, and a differing sample decodes as 0. The first decoded bit of a byte lands in bit 0. Each completed byte is presented on `data_o` with a single-cycle `we_o`.
- R5: The sample point lies on the 5th clock edge after the edge at which a D- transition is first seen, and further samples follow every BIT_CLKS clocks. Bits lasting 10 and 12 clocks alternately are still decoded correctly.
- R6: The bit that follows six consecutive decoded 1s is discarded. It is neither stored nor counted.
- R7: `count_o` is cleared when sync completes and rises by one with each `we_o`, so during the strobe it equals the byte's 1-based position in the packet.
- R8: D+ and D- both low at a sample point produce a one-cycle `done_o`, and the next packet is received normally.
- R9: `err_frame_o` pulses together with `done_o` when decoded data bits are left over since the last completed byte. Those bits are not written.
- R10: When a byte completes after BUF_BYTES bytes have already been written, `err_ovf_o` pulses instead of `we_o`. The rest of the packet is ignored until SE0.
- R11: An SE0 that arrives at the sample point where a stuffed bit is due ends the packet normally, without `err_frame_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, BIT_CLKS cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Synchronized D+ line |
| dm_i | input | 1 | Synchronized D- line |
| data_o | output | 8 | Received byte |
| we_o | output | 1 | One-cycle write strobe for `data_o` |
| count_o | output | $clog2(BUF_BYTES+1) | Bytes written in the current packet |
| done_o | output | 1 | One-cycle end-of-packet pulse |
| err_frame_o | output | 1 | Packet ended mid-byte, pulses with `done_o` |
| err_ovf_o | output | 1 | Buffer overflow abort pulse |
| err_sync_o | output | 1 | Sync timeout abort pulse |

## Verification
Two functions can fall on the same sample point: the end-of-packet detection and the stuffed-bit discard. The bench provokes this by sending a final byte whose last six bits are ones and then omitting the stuffed bit, so that SE0 takes its slot. The result must be a clean `done_o` with the byte already written and no frame error. A second pairing, `done_o` together with `err_frame_o`, is driven by trailing bits after the last full byte. Every pulse is popped from the expected-event queue and compared in kind, data and count.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int STUFF_RUN = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONFIRM,
    ST_HUNT,
    ST_RX,
    ST_DRAIN
  } rx_state_e;
endpackage

// File: rtl/usb_ls_rx_timing.sv
module usb_ls_rx_timing #(
  parameter int BIT_CLKS = 11,
  parameter int CENTER   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dm_i,
  output logic edge_o,
  output logic strobe_o
);
  localparam int PW = $clog2(BIT_CLKS);

  logic          dm_q;
  logic [PW-1:0] ph_q;

  assign edge_o   = dm_i ^ dm_q;
  assign strobe_o = !edge_o && (ph_q == PW'(CENTER));

  // phase restarts on every D- transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dm_q <= 1'b1;
      ph_q <= '0;
    end else begin
      dm_q <= dm_i;
      if (edge_o)                         ph_q <= PW'(1);
      else if (ph_q == PW'(BIT_CLKS - 1)) ph_q <= '0;
      else                                ph_q <= ph_q + PW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx_unstuff.sv
module usb_ls_rx_unstuff #(
  parameter int RUN = usb_ls_rx_pkg::STUFF_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic dm_i,
  output logic bit_vld_o,
  output logic bit_o
);
  localparam int OW = $clog2(RUN + 1);

  logic          last_q;
  logic [OW-1:0] ones_q;
  logic          stuffed;

  assign stuffed   = (ones_q == OW'(RUN));
  assign bit_o     = ~(dm_i ^ last_q);
  assign bit_vld_o = stb_i && !stuffed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      ones_q <= '0;
    end else if (clr_i) begin
      last_q <= 1'b0;  // sync ends on K
      ones_q <= '0;
    end else if (stb_i) begin
      last_q <= dm_i;
      if (stuffed || !bit_o) ones_q <= '0;
      else                   ones_q <= ones_q + OW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx_packer.sv
module usb_ls_rx_packer #(
  parameter int W = usb_ls_rx_pkg::BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         vld_i,
  input  logic         bit_i,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o,
  output logic         partial_o
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] cnt_q;

  assign byte_o      = {bit_i, sh_q[W-1:1]};
  assign byte_done_o = vld_i && (cnt_q == BW'(W - 1));
  assign partial_o   = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (vld_i) begin
      sh_q  <= byte_o;
      cnt_q <= byte_done_o ? '0 : cnt_q + BW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_CLKS      = 11,
  parameter int CENTER        = 5,
  parameter int BUF_BYTES     = 8,
  parameter int SYNC_TMO_BITS = 4,
  localparam int CW           = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              we_o,
  output logic [CW-1:0]     count_o,
  output logic              done_o,
  output logic              err_frame_o,
  output logic              err_ovf_o,
  output logic              err_sync_o
);
  localparam int TMO = SYNC_TMO_BITS * BIT_CLKS;
  localparam int TW  = $clog2(TMO);

  rx_state_e         st_q;
  logic              half_q;
  logic [TW-1:0]     tmo_q;
  logic [CW-1:0]     cnt_q;

  logic              edge_w, stb_w;
  logic              se0, k_lvl, k_edge;
  logic              rx_clr, bit_stb;
  logic              bit_vld, bit_val;
  logic              byte_done, partial;
  logic [BYTE_W-1:0] byte_val;

  assign se0     = !dp_i && !dm_i;
  assign k_lvl   = dp_i && !dm_i;
  assign k_edge  = edge_w && k_lvl;
  assign rx_clr  = (st_q == ST_CONFIRM) && !edge_w && stb_w && half_q && k_lvl;
  assign bit_stb = (st_q == ST_RX) && stb_w && !se0;

  usb_ls_rx_timing #(
    .BIT_CLKS(BIT_CLKS),
    .CENTER  (CENTER)
  ) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dm_i    (dm_i),
    .edge_o  (edge_w),
    .strobe_o(stb_w)
  );

  usb_ls_rx_unstuff #(
    .RUN(STUFF_RUN)
  ) u_unstuff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rx_clr),
    .stb_i    (bit_stb),
    .dm_i     (dm_i),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val)
  );

  usb_ls_rx_packer #(
    .W(BYTE_W)
  ) u_packer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_clr),
    .vld_i      (bit_vld),
    .bit_i      (bit_val),
    .byte_done_o(byte_done),
    .byte_o     (byte_val),
    .partial_o  (partial)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      half_q      <= 1'b0;
      tmo_q       <= '0;
      cnt_q       <= '0;
      data_o      <= '0;
      we_o        <= 1'b0;
      done_o      <= 1'b0;
      err_frame_o <= 1'b0;
      err_ovf_o   <= 1'b0;
      err_sync_o  <= 1'b0;
    end else begin
      we_o        <= 1'b0;
      done_o      <= 1'b0;
      err_frame_o <= 1'b0;
      err_ovf_o   <= 1'b0;
      err_sync_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (k_edge) begin
            st_q   <= ST_CONFIRM;
            half_q <= 1'b0;
          end
        end
        ST_CONFIRM: begin
          if (edge_w) begin
            st_q  <= ST_HUNT;
            tmo_q <= '0;
          end else if (stb_w) begin
            if (!half_q) begin
              half_q <= 1'b1;
            end else if (k_lvl) begin
              st_q  <= ST_RX;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_HUNT;
              tmo_q <= '0;
            end
          end
        end
        ST_HUNT: begin
          if (k_edge) begin
            st_q   <= ST_CONFIRM;
            half_q <= 1'b0;
            tmo_q  <= '0;
          end else if (tmo_q == TW'(TMO - 1)) begin
            st_q       <= ST_IDLE;
            tmo_q      <= '0;
            err_sync_o <= 1'b1;
          end else begin
            tmo_q <= tmo_q + TW'(1);
          end
        end
        ST_RX: begin
          if (stb_w && se0) begin
            st_q        <= ST_IDLE;
            done_o      <= 1'b1;
            err_frame_o <= partial;
          end else if (byte_done) begin
            if (cnt_q == CW'(BUF_BYTES)) begin
              st_q      <= ST_DRAIN;
              err_ovf_o <= 1'b1;
            end else begin
              we_o   <= 1'b1;
              data_o <= byte_val;
              cnt_q  <= cnt_q + CW'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (se0) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_BYTES = 8,
  parameter int CW        = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dp_i,
  input logic          dm_i,
  input logic [7:0]    data_o,
  input logic          we_o,
  input logic [CW-1:0] count_o,
  input logic          done_o,
  input logic          err_frame_o,
  input logic          err_ovf_o,
  input logic          err_sync_o
);
  a_r4_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, done_o, err_ovf_o, err_sync_o}));

  a_r4_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> $stable(data_o));

  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (count_o == CW'($past(count_o) + CW'(1))));

  a_r8_done_on_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!dp_i && !dm_i));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_frame_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_frame_o |-> done_o);

  a_r10_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovf_o |-> (count_o == CW'(BUF_BYTES)));

  a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(BUF_BYTES));
endmodule

bind usb_ls_rx usb_ls_rx_chk #(
  .BUF_BYTES(BUF_BYTES),
  .CW       (CW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dp_i       (dp_i),
  .dm_i       (dm_i),
  .data_o     (data_o),
  .we_o       (we_o),
  .count_o    (count_o),
  .done_o     (done_o),
  .err_frame_o(err_frame_o),
  .err_ovf_o  (err_ovf_o),
  .err_sync_o (err_sync_o)
);

// File: tb/usb_ls_rx_bench.sv
`timescale 1ns/1ps
module usb_ls_rx_bench;
  localparam int BIT_CLKS  = 11;
  localparam int BUF_BYTES = 8;
  localparam int CW        = $clog2(BUF_BYTES + 1);

  typedef enum int {EV_BYTE, EV_DONE, EV_OVF, EV_SYNC} ev_e;
  typedef struct {
    ev_e        kind;
    logic [7:0] data;
    int         cnt;
    bit         frame;
    string      req;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dp = 1'b0;
  logic          dm = 1'b1;
  logic [7:0]    data_o;
  logic          we_o, done_o, err_frame_o, err_ovf_o, err_sync_o;
  logic [CW-1:0] count_o;

  ev_t        exp_q[$];
  logic [7:0] pl[$];
  int n_chk = 0, n_bad = 0, cyc = 0, se0_cyc = 0, ev_seen = 0;
  bit se0_chk = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_ls_rx #(
    .BIT_CLKS (BIT_CLKS),
    .BUF_BYTES(BUF_BYTES)
  ) u_usb_ls_rx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dp_i       (dp),
    .dm_i       (dm),
    .data_o     (data_o),
    .we_o       (we_o),
    .count_o    (count_o),
    .done_o     (done_o),
    .err_frame_o(err_frame_o),
    .err_ovf_o  (err_ovf_o),
    .err_sync_o (err_sync_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic take(input ev_e kind);
    ev_t e;
    ev_seen++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", "unexpected event", int'(kind), -1);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind, e.req, "event kind", int'(kind), int'(e.kind));
    if (kind == EV_BYTE && e.kind == EV_BYTE) begin
      check(data_o == e.data, e.req, "byte value", data_o, e.data);
      check(count_o == CW'(e.cnt), "R7", "byte count", count_o, e.cnt);
    end
    if (kind == EV_DONE && e.kind == EV_DONE) begin
      check(err_frame_o == e.frame, e.frame ? "R9" : "R8", "frame flag",
            err_frame_o, e.frame);
      if (se0_chk) begin
        check(cyc == se0_cyc + 6, "R5", "sample latency after edge",
              cyc - se0_cyc, 6);
        se0_chk = 1'b0;
      end
    end
  endtask

  // monitor: pops expected events as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (we_o)       take(EV_BYTE);
        if (done_o)     take(EV_DONE);
        if (err_ovf_o)  take(EV_OVF);
        if (err_sync_o) take(EV_SYNC);
      end
    end
  end

  // driver: encodes pl plus trailing bits, pushes expectations
  task automatic send(input int xbits, input logic [7:0] xval, input bit omit,
                      input bit jit, input string req);
    int  tx[$];
    int  db[$];
    int  ones, n, len;
    bit  lvl;
    ev_t e;
    n = pl.size();
    for (int i = 0; i < n && i < BUF_BYTES; i++) begin
      e.kind = EV_BYTE; e.data = pl[i]; e.cnt = i + 1; e.frame = 1'b0; e.req = req;
      exp_q.push_back(e);
    end
    e.data = '0; e.cnt = 0; e.req = req; e.frame = (xbits != 0);
    e.kind = (n > BUF_BYTES) ? EV_OVF : EV_DONE;
    exp_q.push_back(e);
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) db.push_back(int'(pl[i][b]));
    for (int b = 0; b < xbits; b++) db.push_back(int'(xval[b]));
    for (int i = 0; i < 7; i++) tx.push_back(0);
    tx.push_back(1);
    ones = 0;
    for (int i = 0; i < db.size(); i++) begin
      tx.push_back(db[i]);
      ones = (db[i] != 0) ? ones + 1 : 0;
      if (ones == 6) begin
        if (!(omit && i == db.size() - 1)) tx.push_back(0);
        ones = 0;
      end
    end
    lvl = 1'b1;
    for (int k = 0; k < tx.size(); k++) begin
      if (tx[k] == 0) lvl = !lvl;
      dm = lvl; dp = !lvl;
      len = (jit && k >= 8) ? ((k % 2 != 0) ? 12 : 10) : BIT_CLKS;
      repeat (len) @(negedge clk);
    end
    se0_chk = (n <= BUF_BYTES) && lvl;
    se0_cyc = cyc;
    dm = 1'b0; dp = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);
    dm = 1'b1; dp = 1'b0;
    repeat (3 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, "events still pending", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({data_o, we_o, count_o, done_o, err_frame_o, err_ovf_o, err_sync_o} == '0,
          "R1", "outputs after reset",
          {data_o, we_o, count_o, done_o, err_frame_o, err_ovf_o, err_sync_o}, 0);
    // R1 idle J produces nothing
    seen = ev_seen;
    repeat (200) @(negedge clk);
    check(ev_seen == seen, "R1", "events during idle", ev_seen - seen, 0);

    // R2 R4: sync lock and NRZI decode, R8 end of packet
    pl.delete(); pl.push_back(8'hC3); pl.push_back(8'h5A); pl.push_back(8'h01);
    send(0, 8'h00, 1'b0, 1'b0, "R2 R4");
    drained("R8");

    // R6: long runs of ones
    pl.delete(); pl.push_back(8'hFF); pl.push_back(8'hFF); pl.push_back(8'h7E);
    send(0, 8'h00, 1'b0, 1'b0, "R6");
    drained("R6");

    // R5: alternating 10/12 clock bits
    pl.delete(); pl.push_back(8'h96); pl.push_back(8'h3C); pl.push_back(8'hE1);
    send(0, 8'h00, 1'b0, 1'b1, "R5");
    drained("R5");

    // R9: three trailing bits
    pl.delete(); pl.push_back(8'h12);
    send(3, 8'h05, 1'b0, 1'b0, "R9");
    drained("R9");

    // R10: overflow, then recovery
    pl.delete();
    for (int i = 1; i <= BUF_BYTES + 2; i++) pl.push_back(8'(i * 17));
    send(0, 8'h00, 1'b0, 1'b0, "R10");
    drained("R10");
    pl.delete(); pl.push_back(8'hA5);
    send(0, 8'h00, 1'b0, 1'b0, "R8");
    drained("R8");

    // R3: lone K then idle, then a normal packet
    begin
      ev_t e;
      e.kind = EV_SYNC; e.data = '0; e.cnt = 0; e.frame = 1'b0; e.req = "R3";
      exp_q.push_back(e);
      dm = 1'b0; dp = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
      dm = 1'b1; dp = 1'b0;
      repeat (8 * BIT_CLKS) @(negedge clk);
      drained("R3");
    end
    pl.delete(); pl.push_back(8'h5C);
    send(0, 8'h00, 1'b0, 1'b0, "R2");
    drained("R2");

    // R11: SE0 in the stuffed-bit slot; R6 with the stuffed bit present
    pl.delete(); pl.push_back(8'h11); pl.push_back(8'hFC);
    send(0, 8'h00, 1'b1, 1'b0, "R11");
    drained("R11");
    send(0, 8'h00, 1'b0, 1'b0, "R6");
    drained("R6");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule